// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a 16-bit down-counter that raises a periodic interrupt. A prescaler inside the block divides the system clock into a one-cycle tick (by default 2500 cycles, giving 100 µs at 25 MHz). While the timer is enabled, each tick takes one off the live count. When the count passes from 0000h, it wraps to FFFFh and a sticky status flag is set. The level interrupt request follows the status flag, gated by an interrupt enable.

Software controls the block through plain register-style pins:
- an enable level;
- a write strobe with data for the reload value;
- a write strobe with one data bit for clearing the status flag.

The live count and the reload value can be read on output pins at any time. There is no data stream, so no valid/ready handshake is used. Writes are single-cycle strobes and are never back-pressured.

Top module: `periodic_dn_timer`

## Requirements
- R1: After reset the count and the reload value both read FFFFh, and the status flag and the interrupt request read 0.
- R2: In the first cycle in which enable is sampled high after being low, the count is loaded from the reload value. If a reload write happens in that same cycle, the count is loaded with the written data instead.
- R3: While enabled, the count drops by one on each tick. Ticks come every TICK_DIV cycles. The prescaler is held cleared while disabled, so the first decrement comes TICK_DIV cycles after the enabling edge.
- R4: A tick that finds the count at 0000h moves it to FFFFh (never to the reload value), sets the status flag, and counting goes on.
- R5: A reload write stores the data at any time. While enabled, the write also replaces the count. This takes priority over a tick in the same cycle, and no status event is produced for that cycle.
- R6: When enable is sampled low after being high, the reload value is forced to FFFFh, overriding a reload write in that cycle. While disabled, the count holds and no status events occur.
- R7: The status flag is sticky and is cleared by a status write with data bit 1. If a wrap and a clearing write occur in the same cycle, the flag ends up set.
- R8: The interrupt request is high exactly when the status flag is 1 and the interrupt enable is 1.
- R9: A status write with data bit 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer enable level |
| irq_en | input | 1 | Interrupt enable |
| rld_wr | input | 1 | Reload write strobe |
| rld_wdata | input | 16 | Reload write data |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Status write data (1 clears) |
| count | output | 16 | Live count |
| reload | output | 16 | Current reload value |
| sts | output | 1 | Sticky status flag |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the first tick after enabling. A prescaler that is not held cleared would decrement early or at a random phase. It also checks the wrap from 0000h: a design that reloaded there would show the reload value instead of FFFFh, and one that did not set the flag would never interrupt. It drives a clearing write held across a wrap; a clear-wins priority would drop that event. Enable is dropped together with a reload write to catch a design that lets the write survive the forced FFFFh. Random reload writes of small values make reload and tick collide often, which exposes a decrement or spurious status taking priority over the write.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int unsigned DEF_CNT_W    = 16;
  localparam int unsigned DEF_TICK_DIV = 2500;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_RISE = 2'd1,
    PH_FALL = 2'd2,
    PH_ON   = 2'd3
  } run_phase_e;
endpackage

// File: rtl/pdt_phase.sv
module pdt_phase
  import pdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  output run_phase_e phase
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end

  always_comb begin
    unique case ({run_q, run_en})
      2'b01:   phase = PH_RISE;
      2'b10:   phase = PH_FALL;
      2'b11:   phase = PH_ON;
      default: phase = PH_OFF;
    endcase
  end
endmodule

// File: rtl/pdt_prescale.sv
module pdt_prescale #(
  parameter int unsigned DIV = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (!run)         div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end

      assign tick = run && (div_q == LAST);

      p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      p_no_tick_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !tick);
    end
  endgenerate
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter
  import pdt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  run_phase_e   phase,
  input  logic         run,
  input  logic         tick,
  input  logic         rld_wr,
  input  logic [W-1:0] rld_wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic         wrap
);
  localparam logic [W-1:0] ONES = '1;

  logic wr_live;
  assign wr_live = run && rld_wr;
  assign wrap    = tick && !wr_live && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               reload <= ONES;
    else if (phase == PH_FALL) reload <= ONES;
    else if (rld_wr)          reload <= rld_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= ONES;
    else if (wr_live)          count <= rld_wdata;
    else if (phase == PH_RISE) count <= reload;
    else if (tick)             count <= count - 1'b1;
  end

  p_wrap_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == ONES);
  p_live_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> count == $past(rld_wdata));
  p_fall_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FALL) |=> reload == ONES);
  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> $stable(count));
endmodule

// File: rtl/pdt_status.sv
module pdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic sts_wr,
  input  logic sts_wdata,
  input  logic irq_en,
  output logic sts,
  output logic irq
);
  logic clr;
  assign clr = sts_wr && sts_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sts <= 1'b0;
    else if (wrap) sts <= 1'b1;
    else if (clr)  sts <= 1'b0;
  end

  assign irq = sts && irq_en;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> sts);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr) |=> sts);
  p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !sts_wdata && !wrap) |=> $stable(sts));
endmodule

// File: rtl/periodic_dn_timer.sv
module periodic_dn_timer
  import pdt_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             irq_en,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] rld_wdata,
  input  logic             sts_wr,
  input  logic             sts_wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             sts,
  output logic             irq
);
  run_phase_e phase;
  logic       tick;
  logic       wrap;

  pdt_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .phase  (phase)
  );

  pdt_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_en),
    .tick  (tick)
  );

  pdt_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .run       (run_en),
    .tick      (tick),
    .rld_wr    (rld_wr),
    .rld_wdata (rld_wdata),
    .count     (count),
    .reload    (reload),
    .wrap      (wrap)
  );

  pdt_status u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap      (wrap),
    .sts_wr    (sts_wr),
    .sts_wdata (sts_wdata),
    .irq_en    (irq_en),
    .sts       (sts),
    .irq       (irq)
  );

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/tb_periodic_dn_timer.sv
module tb_periodic_dn_timer;
  localparam int W   = 16;
  localparam int DIV = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_en = 1'b0, irq_en = 1'b0, rld_wr = 1'b0, sts_wr = 1'b0, sts_wdata = 1'b0;
  logic [W-1:0] rld_wdata = '0;
  logic [W-1:0] count, reload;
  logic         sts, irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  periodic_dn_timer #(.CNT_W(W), .TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .irq_en(irq_en),
    .rld_wr(rld_wr), .rld_wdata(rld_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .count(count), .reload(reload), .sts(sts), .irq(irq)
  );

  // reference model built from the requirements
  logic [W-1:0] m_cnt, m_rld;
  logic         m_sts, m_run_q;
  int           m_div;

  function automatic logic [W-1:0] next_count(logic [W-1:0] c, logic run, logic rise,
                                               logic wr, logic [W-1:0] d, logic [W-1:0] r,
                                               logic tk);
    if (run && wr)   return d;           // R5
    else if (rise)   return r;           // R2
    else if (tk)     return c - 1'b1;    // R3 / R4 wrap to all ones
    return c;                            // R6 hold
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '1; m_rld = '1; m_sts = 0; m_run_q = 0; m_div = 0;
    end else begin
      logic tk, rise, fall, wrp;
      tk   = run_en && (m_div == DIV - 1);
      rise = run_en && !m_run_q;
      fall = !run_en && m_run_q;
      wrp  = tk && !(run_en && rld_wr) && (m_cnt == 0);
      m_cnt = next_count(m_cnt, run_en, rise, rld_wr, rld_wdata, m_rld, tk);
      if (fall)        m_rld = '1;
      else if (rld_wr) m_rld = rld_wdata;
      if (wrp)                         m_sts = 1;
      else if (sts_wr && sts_wdata)    m_sts = 0;
      m_div   = !run_en ? 0 : (m_div == DIV - 1 ? 0 : m_div + 1);
      m_run_q = run_en;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R3 count", 32'(count), 32'(m_cnt));
    chk("R5 reload", 32'(reload), 32'(m_rld));
    chk("R7 status", 32'(sts), 32'(m_sts));
    chk("R8 irq", 32'(irq), 32'(m_sts && irq_en));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] held;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 32'hFFFF);
    chk("R1 reload", 32'(reload), 32'hFFFF);
    chk("R1 status", 32'(sts), 0);
    chk("R1 irq", 32'(irq), 0);

    // R5 write while disabled: stored, count untouched
    rld_wr = 1; rld_wdata = 16'd3;
    step();
    rld_wr = 0;
    chk("R5 reload stored", 32'(reload), 3);
    chk("R6 count held off", 32'(count), 32'hFFFF);

    // R2 enable loads count
    run_en = 1;
    step();
    chk("R2 load on enable", 32'(count), 3);
    repeat (DIV - 2) step();
    chk("R3 no early tick", 32'(count), 3);
    step();
    chk("R3 first decrement", 32'(count), 2);

    // R4 wrap to all ones, not reload
    repeat (3 * DIV) step();
    chk("R4 wrap value", 32'(count), 32'hFFFF);
    chk("R4 status set", 32'(sts), 1);
    chk("R8 irq masked", 32'(irq), 0);
    irq_en = 1;
    step();
    chk("R8 irq raised", 32'(irq), 1);

    // R9 write zero ignored, R7 write one clears
    sts_wr = 1; sts_wdata = 0;
    step();
    chk("R9 zero write", 32'(sts), 1);
    sts_wdata = 1;
    step();
    sts_wr = 0;
    chk("R7 clear", 32'(sts), 0);
    chk("R8 irq drops", 32'(irq), 0);

    // R5 live write restarts; R7 set beats held clear
    rld_wr = 1; rld_wdata = 16'd0;
    step();
    rld_wr = 0;
    chk("R5 live restart", 32'(count), 0);
    sts_wr = 1; sts_wdata = 1;
    for (int i = 0; i < 2 * DIV && count == 0; i++) step();
    chk("R4 wrap after restart", 32'(count), 32'hFFFF);
    chk("R7 set wins over clear", 32'(sts), 1);
    step();
    sts_wr = 0;
    chk("R7 cleared after", 32'(sts), 0);

    // R6 disable forces reload over same-cycle write, count holds
    run_en = 0; rld_wr = 1; rld_wdata = 16'd7;
    step();
    rld_wr = 0;
    chk("R6 reload forced", 32'(reload), 32'hFFFF);
    held = count;
    repeat (3 * DIV) step();
    chk("R6 count holds", 32'(count), 32'(held));
    chk("R6 no status", 32'(sts), 0);

    // constrained random
    for (int n = 0; n < 20000; n++) begin
      if ($urandom % 64 == 0) run_en = ~run_en;
      if ($urandom % 32 == 0) irq_en = ~irq_en;
      rld_wr    = ($urandom % 24 == 0);
      rld_wdata = ($urandom % 4 != 0) ? W'($urandom % 6) : W'($urandom);
      sts_wr    = ($urandom % 12 == 0);
      sts_wdata = 1'($urandom);
      step();
    end
    rld_wr = 0; sts_wr = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule